// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block sits at the front of an out-of-order core whose architectural state and speculative results share a single merged file of 64 physical registers. Every cycle it takes a group of up to four instructions in program order and renames them together. Each source operand, up to three per instruction, is looked up in a 32-entry table that maps architectural registers to physical registers. Each instruction that writes a register receives a fresh physical register from a free pool. The group is renamed as a whole, so a source that depends on a destination written earlier in the same group receives that earlier instruction's new tag rather than the stale table entry.

For every destination the block also reports the physical register that the architectural register was mapped to before this write. The commit logic later hands that previous register back through a four-wide release port. At the same time, commit advances a committed copy of the map. A flush request drops all speculative mappings. The block spends one cycle in a restore state and then resumes with the committed map. In that state the free pool is rebuilt as every physical register that the committed map does not name.

Control is a two-state machine. ACTIVE accepts groups. A flush in ACTIVE moves it to RESTORE. RESTORE returns to ACTIVE when no flush is present, and stays in RESTORE when a new flush arrives. While in RESTORE no group is accepted, and at the end of the cycle the speculative state is reloaded from the committed state.

Top module: `rn_rename4`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i in 0..31, and physical registers 32..63 are free. `ren_ready_o` is 1.
- R2: Each source tag output equals the physical register currently mapped to that source's architectural register, unless R4 applies.
- R3: When a group is accepted, each slot with `ren_valid_i` and `ren_has_dst_i` both set receives a distinct free physical register. Registers are handed out lowest-numbered first, and slots are served in slot order 0 to 3.
- R4: A source in slot j that names the destination of an earlier valid slot i < j in the same group takes the new tag of the latest such slot.
- R5: The old-tag output of a destination slot is the table mapping before the group, or the new tag of the latest earlier slot in the group that writes the same architectural register.
- R6: After an accepted group, the table holds for each written architectural register the tag of the last slot in the group that writes it.
- R7: When the free pool holds fewer registers than the group needs, `ren_accept_o` is 0. In that case nothing is allocated and the table is unchanged.
- R8: Each valid commit entry returns `cm_old_i` to the free pool, and that register can be allocated from the next cycle onward. It also sets the committed mapping of `cm_arch_i` to `cm_new_i`. Entries are applied in order 0 to 3.
- R9: In a cycle where `flush_i` is 1, no group is accepted and the block then spends exactly one RESTORE cycle with `ren_ready_o` at 0. After RESTORE, the table equals the committed map and the free pool holds exactly the registers the committed map does not name.
- R10: Slots with `ren_valid_i` at 0, or with no destination, consume no free register and write nothing into the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard speculative mappings, restore from committed state |
| ren_valid_i | input | 4 | Per-slot instruction valid |
| ren_has_dst_i | input | 4 | Per-slot destination present |
| ren_dst_i | input | 4x5 | Per-slot architectural destination |
| ren_src_i | input | 4x3x5 | Per-slot architectural sources |
| ren_ready_o | output | 1 | Machine in ACTIVE and no flush this cycle |
| ren_accept_o | output | 1 | Group renamed and state updated at this edge |
| ren_src_tag_o | output | 4x3x6 | Physical tags of the sources |
| ren_dst_tag_o | output | 4x6 | Newly allocated destination tags |
| ren_old_tag_o | output | 4x6 | Previous mapping of each destination |
| cm_valid_i | input | 4 | Per-entry commit valid |
| cm_arch_i | input | 4x5 | Committed architectural destination |
| cm_new_i | input | 4x6 | Physical register that becomes committed |
| cm_old_i | input | 4x6 | Physical register released to the pool |

## Verification
Directed groups first check renaming against an independent sources that all hit the table. Later groups add chains within a group, repeated writes to the same register, and empty or destination-free slots, which separates table reads from in-group forwarding and last-writer selection. The free pool is drained until a group stalls, and then refilled by commits in the same cycle as a request, which shows that freed registers become usable one cycle later. Flushes after partial commits, together with a long stream of pseudo-random groups, commits in program order and occasional flushes, check that the restored map and pool match the committed state.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic {
        RN_ACTIVE  = 1'b0,
        RN_RESTORE = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    output logic ready,
    output logic restore
);
    rn_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RN_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        restore = 1'b0;
        unique case (state_q)
            RN_ACTIVE: begin
                ready   = !flush;
                state_d = flush ? RN_RESTORE : RN_ACTIVE;
            end
            RN_RESTORE: begin
                restore = 1'b1;
                state_d = flush ? RN_RESTORE : RN_ACTIVE;
            end
            default: state_d = RN_ACTIVE;
        endcase
    end

    // R9: restore lasts one cycle unless flushed again
    a_r9_restore_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RN_RESTORE && !flush) |=> state_q == RN_ACTIVE);
    a_r9_flush_enters_restore: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> restore);
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int NPHYS = 64,
    parameter int NARCH = 32,
    parameter int W     = 4,
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(NPHYS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          need,
    input  logic                  alloc_en,
    input  logic [W-1:0]          fr_valid,
    input  logic [W-1:0][PW-1:0]  fr_tag,
    input  logic                  restore_load,
    input  logic [NPHYS-1:0]      restore_mask,
    output logic [W-1:0][PW-1:0]  grant_tag,
    output logic                  enough
);
    logic [NPHYS-1:0]     free_q, free_d, take_mask, give_mask, reset_mask;
    logic [W-1:0][PW-1:0] pick;
    logic [CW-1:0]        free_cnt;
    int                   ndst;

    always_comb begin
        for (int p = 0; p < NPHYS; p++) reset_mask[p] = (p >= NARCH);
    end

    // lowest-numbered free registers, in order
    always_comb begin
        logic [NPHYS-1:0] scan;
        logic             got;
        scan = free_q;
        for (int k = 0; k < W; k++) begin
            pick[k] = '0;
            got     = 1'b0;
            for (int p = 0; p < NPHYS; p++) begin
                if (scan[p] && !got) begin
                    pick[k] = PW'(p);
                    got     = 1'b1;
                end
            end
            if (got) scan[pick[k]] = 1'b0;
        end
    end

    // slot j gets the pick whose rank equals the number of earlier needing slots
    always_comb begin
        int rank;
        rank = 0;
        for (int j = 0; j < W; j++) begin
            grant_tag[j] = pick[rank];
            if (need[j]) rank = rank + 1;
        end
        ndst = rank;
    end

    assign free_cnt = CW'($countones(free_q));
    assign enough   = (int'(free_cnt) >= ndst);

    always_comb begin
        take_mask = '0;
        give_mask = '0;
        for (int j = 0; j < W; j++)
            if (alloc_en && need[j]) take_mask[grant_tag[j]] = 1'b1;
        for (int k = 0; k < W; k++)
            if (fr_valid[k]) give_mask[fr_tag[k]] = 1'b1;
        if (restore_load) free_d = restore_mask;
        else              free_d = (free_q & ~take_mask) | give_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= reset_mask;
        else        free_q <= free_d;
    end

    // R3: every granted register was free, and one per needing slot
    a_r3_grant_was_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (take_mask & ~free_q) == '0);
    a_r3_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> $countones(take_mask) == ndst);
    // R7: a stalled cycle only gains released registers
    a_r7_stall_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_en && !restore_load) |=> free_q == ($past(free_q) | $past(give_mask)));
    // R8: a released register was not already free
    a_r8_no_double_free: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_load |-> (give_mask & free_q) == '0);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int W     = 4,
    parameter int NSRC  = 3,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [W-1:0][NSRC-1:0][AW-1:0] rd_arch,
    input  logic [W-1:0][AW-1:0]           dst_arch,
    input  logic [W-1:0]                   wr_en,
    input  logic [W-1:0][PW-1:0]           wr_tag,
    input  logic [W-1:0]                   cm_valid,
    input  logic [W-1:0][AW-1:0]           cm_arch,
    input  logic [W-1:0][PW-1:0]           cm_new,
    input  logic [W-1:0][PW-1:0]           cm_old,
    input  logic                           restore,
    output logic [W-1:0][NSRC-1:0][PW-1:0] rd_tag,
    output logic [W-1:0][PW-1:0]           old_raw,
    output logic [NPHYS-1:0]               restore_free
);
    logic [NARCH-1:0][PW-1:0] map_q, map_d, cmap_q, cmap_d;
    logic [NPHYS-1:0]         cused_q, cused_d;

    generate
        for (genvar j = 0; j < W; j++) begin : g_slot
            for (genvar s = 0; s < NSRC; s++) begin : g_src
                assign rd_tag[j][s] = map_q[rd_arch[j][s]];
            end
            assign old_raw[j] = map_q[dst_arch[j]];
        end
    endgenerate

    always_comb begin
        cmap_d  = cmap_q;
        cused_d = cused_q;
        for (int k = 0; k < W; k++) begin
            if (cm_valid[k]) begin
                cmap_d[cm_arch[k]] = cm_new[k];
                cused_d[cm_new[k]] = 1'b1;
                cused_d[cm_old[k]] = 1'b0;
            end
        end
    end

    assign restore_free = ~cused_d;

    always_comb begin
        map_d = map_q;
        if (restore) begin
            map_d = cmap_d;
        end else begin
            for (int j = 0; j < W; j++)
                if (wr_en[j]) map_d[dst_arch[j]] = wr_tag[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) begin
                map_q[i]  <= PW'(i);
                cmap_q[i] <= PW'(i);
            end
            for (int p = 0; p < NPHYS; p++) cused_q[p] <= (p < NARCH);
        end else begin
            map_q   <= map_d;
            cmap_q  <= cmap_d;
            cused_q <= cused_d;
        end
    end

    // R6: the last slot's write always lands in the table
    a_r6_last_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[W-1] && !restore) |=> map_q[$past(dst_arch[W-1])] == $past(wr_tag[W-1]));
    // R8: a committed register enters committed use
    a_r8_commit_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid[W-1] && cm_new[W-1] != cm_old[W-1]) |=> cused_q[$past(cm_new[W-1])]);
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
    parameter int W    = 4,
    parameter int NSRC = 3,
    parameter int AW   = 5,
    parameter int PW   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [W-1:0]                   need,
    input  logic [W-1:0][AW-1:0]           dst_arch,
    input  logic [W-1:0][NSRC-1:0][AW-1:0] src_arch,
    input  logic [W-1:0][PW-1:0]           new_tag,
    input  logic [W-1:0][NSRC-1:0][PW-1:0] raw_src,
    input  logic [W-1:0][PW-1:0]           raw_old,
    output logic [W-1:0][NSRC-1:0][PW-1:0] src_tag,
    output logic [W-1:0][PW-1:0]           old_tag
);
    always_comb begin
        for (int j = 0; j < W; j++) begin
            for (int s = 0; s < NSRC; s++) begin
                src_tag[j][s] = raw_src[j][s];
                for (int i = 0; i < j; i++)
                    if (need[i] && dst_arch[i] == src_arch[j][s])
                        src_tag[j][s] = new_tag[i];
            end
            old_tag[j] = raw_old[j];
            for (int i = 0; i < j; i++)
                if (need[i] && dst_arch[i] == dst_arch[j])
                    old_tag[j] = new_tag[i];
        end
    end

    // R4: slot 1 first source forwarded from slot 0
    a_r4_fwd_slot1: assert property (@(posedge clk) disable iff (!rst_n)
        (need[0] && dst_arch[0] == src_arch[1][0]) |-> src_tag[1][0] == new_tag[0]);
    // R5: slot 1 rewriting slot 0's register reports slot 0's new tag as old
    a_r5_old_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (need[0] && need[1] && dst_arch[0] == dst_arch[1]) |-> old_tag[1] == new_tag[0]);
endmodule

// File: rtl/rn_rename4.sv
module rn_rename4 #(
    parameter int NARCH = 32,
    parameter int NPHYS = 64,
    parameter int W     = 4,
    parameter int NSRC  = 3,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush_i,
    input  logic [W-1:0]                   ren_valid_i,
    input  logic [W-1:0]                   ren_has_dst_i,
    input  logic [W-1:0][AW-1:0]           ren_dst_i,
    input  logic [W-1:0][NSRC-1:0][AW-1:0] ren_src_i,
    output logic                           ren_ready_o,
    output logic                           ren_accept_o,
    output logic [W-1:0][NSRC-1:0][PW-1:0] ren_src_tag_o,
    output logic [W-1:0][PW-1:0]           ren_dst_tag_o,
    output logic [W-1:0][PW-1:0]           ren_old_tag_o,
    input  logic [W-1:0]                   cm_valid_i,
    input  logic [W-1:0][AW-1:0]           cm_arch_i,
    input  logic [W-1:0][PW-1:0]           cm_new_i,
    input  logic [W-1:0][PW-1:0]           cm_old_i
);
    logic                           ready, restore, enough;
    logic [W-1:0]                   need, wr_en;
    logic [W-1:0][PW-1:0]           grant_tag, raw_old;
    logic [W-1:0][NSRC-1:0][PW-1:0] raw_src;
    logic [NPHYS-1:0]               restore_free;

    assign need         = ren_valid_i & ren_has_dst_i;
    assign ren_ready_o  = ready;
    assign ren_accept_o = ready && enough;
    assign wr_en        = need & {W{ren_accept_o}};
    assign ren_dst_tag_o = grant_tag;

    rn_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_i),
        .ready   (ready),
        .restore (restore)
    );

    rn_free_pool #(.NPHYS(NPHYS), .NARCH(NARCH), .W(W)) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .need         (need),
        .alloc_en     (ren_accept_o),
        .fr_valid     (cm_valid_i),
        .fr_tag       (cm_old_i),
        .restore_load (restore),
        .restore_mask (restore_free),
        .grant_tag    (grant_tag),
        .enough       (enough)
    );

    rn_map_table #(.NARCH(NARCH), .NPHYS(NPHYS), .W(W), .NSRC(NSRC)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_arch      (ren_src_i),
        .dst_arch     (ren_dst_i),
        .wr_en        (wr_en),
        .wr_tag       (grant_tag),
        .cm_valid     (cm_valid_i),
        .cm_arch      (cm_arch_i),
        .cm_new       (cm_new_i),
        .cm_old       (cm_old_i),
        .restore      (restore),
        .rd_tag       (raw_src),
        .old_raw      (raw_old),
        .restore_free (restore_free)
    );

    rn_bypass #(.W(W), .NSRC(NSRC), .AW(AW), .PW(PW)) u_byp (
        .clk      (clk),
        .rst_n    (rst_n),
        .need     (need),
        .dst_arch (ren_dst_i),
        .src_arch (ren_src_i),
        .new_tag  (grant_tag),
        .raw_src  (raw_src),
        .raw_old  (raw_old),
        .src_tag  (ren_src_tag_o),
        .old_tag  (ren_old_tag_o)
    );

    // R9: nothing is accepted in a flush cycle or the cycle after it
    a_r9_flush_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !ren_accept_o);
    a_r9_after_flush_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !ren_ready_o);
    // R3: two destination slots never share a tag
    a_r3_distinct_01: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_accept_o && need[0] && need[1]) |-> ren_dst_tag_o[0] != ren_dst_tag_o[1]);
endmodule

// File: tb/rn_rename4_tb.sv
module rn_rename4_tb;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0, flush_i = 0;
    logic [3:0]           ren_valid_i = 0, ren_has_dst_i = 0;
    logic [3:0][4:0]      ren_dst_i = 0;
    logic [3:0][2:0][4:0] ren_src_i = 0;
    logic                 ren_ready_o, ren_accept_o;
    logic [3:0][2:0][5:0] ren_src_tag_o;
    logic [3:0][5:0]      ren_dst_tag_o, ren_old_tag_o;
    logic [3:0]           cm_valid_i = 0;
    logic [3:0][4:0]      cm_arch_i = 0;
    logic [3:0][5:0]      cm_new_i = 0, cm_old_i = 0;

    always #(CLK_P/2) clk = ~clk;

    rn_rename4 u_dut (.*);

    typedef struct {
        bit       acc;
        bit [3:0] v, hd;
        int       src[4][3];
        int       dst[4];
        int       old[4];
        string    req;
    } exp_t;
    typedef struct { int arch; int nw; int old; } fl_t;

    exp_t exp_q[$];
    fl_t  infl[$];
    int n_chk = 0, n_bad = 0;

    // reference state
    int mmap[32], mcmap[32];
    bit mfree[64], mcused[64];
    bit mrestore;

    // stimulus staging
    bit [3:0] g_v, g_hd;
    int g_d[4], g_s[4][3];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic cycle(input int ncm, input bit fl, input string req);
        exp_t e;
        fl_t  cms[$];
        int   nd, fc, rank;
        int   picks[4];
        bit   scan[64];
        @(negedge clk);
        cm_valid_i = 0;
        for (int k = 0; k < 4; k++) begin
            if (k < ncm && infl.size() > 0) begin
                fl_t it;
                it = infl.pop_front();
                cms.push_back(it);
                cm_valid_i[k] = 1;
                cm_arch_i[k] = 5'(it.arch);
                cm_new_i[k]  = 6'(it.nw);
                cm_old_i[k]  = 6'(it.old);
            end
        end
        flush_i = fl;
        ren_valid_i = g_v;
        ren_has_dst_i = g_hd;
        for (int j = 0; j < 4; j++) begin
            ren_dst_i[j] = 5'(g_d[j]);
            for (int s = 0; s < 3; s++) ren_src_i[j][s] = 5'(g_s[j][s]);
        end
        // expectation
        nd = 0; fc = 0;
        for (int j = 0; j < 4; j++) if (g_v[j] && g_hd[j]) nd++;
        for (int p = 0; p < 64; p++) begin scan[p] = mfree[p]; if (mfree[p]) fc++; end
        for (int k = 0; k < 4; k++) begin
            picks[k] = 0;
            for (int p = 63; p >= 0; p--) if (scan[p]) picks[k] = p;
            if (scan[picks[k]]) scan[picks[k]] = 0;
        end
        e.acc = !mrestore && !fl && (fc >= nd);
        e.v = g_v; e.hd = g_hd; e.req = req;
        rank = 0;
        for (int j = 0; j < 4; j++) begin
            e.dst[j] = picks[rank];
            if (g_v[j] && g_hd[j]) rank++;
            for (int s = 0; s < 3; s++) begin
                e.src[j][s] = mmap[g_s[j][s]];
                for (int i = 0; i < j; i++)
                    if (g_v[i] && g_hd[i] && g_d[i] == g_s[j][s]) e.src[j][s] = e.dst[i];
            end
            e.old[j] = mmap[g_d[j]];
            for (int i = 0; i < j; i++)
                if (g_v[i] && g_hd[i] && g_d[i] == g_d[j]) e.old[j] = e.dst[i];
        end
        exp_q.push_back(e);
        // state update
        if (e.acc) begin
            for (int j = 0; j < 4; j++) if (g_v[j] && g_hd[j]) begin
                fl_t it;
                mmap[g_d[j]] = e.dst[j];
                mfree[e.dst[j]] = 0;
                it.arch = g_d[j]; it.nw = e.dst[j]; it.old = e.old[j];
                infl.push_back(it);
            end
        end
        foreach (cms[k]) begin
            mfree[cms[k].old] = 1;
            mcmap[cms[k].arch] = cms[k].nw;
            mcused[cms[k].nw] = 1;
            mcused[cms[k].old] = 0;
        end
        if (mrestore) begin
            for (int i = 0; i < 32; i++) mmap[i] = mcmap[i];
            for (int p = 0; p < 64; p++) mfree[p] = !mcused[p];
        end
        if (fl) infl.delete();
        mrestore = fl;
    endtask

    task automatic set_slot(input int j, input bit v, input bit hd, input int d, input int s0, input int s1, input int s2);
        g_v[j] = v; g_hd[j] = hd; g_d[j] = d;
        g_s[j][0] = s0; g_s[j][1] = s1; g_s[j][2] = s2;
    endtask

    task automatic clear_slots();
        for (int j = 0; j < 4; j++) set_slot(j, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic int free_count();
        int c = 0;
        for (int p = 0; p < 64; p++) if (mfree[p]) c++;
        return c;
    endfunction

    // monitor: compares each expected item against the ports mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(ren_accept_o == e.acc, e.req, "accept", int'(ren_accept_o), int'(e.acc));
                if (e.acc) begin
                    for (int j = 0; j < 4; j++) if (e.v[j]) begin
                        for (int s = 0; s < 3; s++)
                            chk(int'(ren_src_tag_o[j][s]) == e.src[j][s], e.req, "src_tag",
                                int'(ren_src_tag_o[j][s]), e.src[j][s]);
                        if (e.hd[j]) begin
                            chk(int'(ren_dst_tag_o[j]) == e.dst[j], e.req, "dst_tag",
                                int'(ren_dst_tag_o[j]), e.dst[j]);
                            chk(int'(ren_old_tag_o[j]) == e.old[j], e.req, "old_tag",
                                int'(ren_old_tag_o[j]), e.old[j]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin mmap[i] = i; mcmap[i] = i; end
        for (int p = 0; p < 64; p++) begin mfree[p] = (p >= 32); mcused[p] = (p < 32); end
        mrestore = 0;
        clear_slots();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #(CLK_P/4);
        chk(ren_ready_o == 1'b1, "R1", "ready after reset", int'(ren_ready_o), 1);

        // R1 R2 R3: identity map and lowest free register first
        set_slot(0, 1, 1, 3, 5, 0, 31);
        cycle(0, 0, "R1");
        clear_slots();
        // R4 R5 R6: chains and repeated writes inside one group
        set_slot(0, 1, 1, 1, 1, 2, 3);
        set_slot(1, 1, 1, 2, 1, 3, 4);
        set_slot(2, 1, 0, 7, 2, 1, 3);
        set_slot(3, 1, 1, 1, 2, 1, 1);
        cycle(0, 0, "R4");
        // R6: table holds the last writer; R2 table read
        clear_slots();
        set_slot(0, 1, 0, 0, 1, 2, 3);
        set_slot(1, 1, 1, 9, 9, 8, 7);
        cycle(0, 0, "R6");
        // R10: invalid and destination-free slots consume nothing
        clear_slots();
        set_slot(0, 0, 1, 4, 4, 4, 4);
        set_slot(1, 1, 0, 4, 4, 5, 6);
        cycle(0, 0, "R10");
        clear_slots();
        set_slot(0, 1, 1, 4, 4, 0, 0);
        cycle(0, 0, "R10");
        // R7: drain the pool, then stall
        clear_slots();
        for (int j = 0; j < 4; j++) set_slot(j, 1, 1, 10 + j, 10 + j, 20, 21);
        while (free_count() >= 4) cycle(0, 0, "R3");
        cycle(0, 0, "R7");
        clear_slots();
        set_slot(0, 1, 0, 0, 10, 11, 12);
        set_slot(1, 1, 0, 0, 13, 1, 2);
        cycle(0, 0, "R7");
        // R8: released registers usable from the next cycle
        for (int j = 0; j < 4; j++) set_slot(j, 1, 1, 16 + j, j, 16, 17);
        cycle(4, 0, "R8");
        cycle(0, 0, "R8");
        // R9: commit some, then flush and restore
        cycle(3, 0, "R8");
        cycle(2, 1, "R9");
        cycle(0, 0, "R9");
        clear_slots();
        for (int j = 0; j < 4; j++) set_slot(j, 1, 1, 1 + j, 10 + j, 16 + j, 1 + j);
        cycle(0, 0, "R9");
        for (int j = 0; j < 4; j++) set_slot(j, 1, 0, 0, 4 * j, 4 * j + 1, 4 * j + 2);
        cycle(0, 0, "R9");
        for (int j = 0; j < 4; j++) set_slot(j, 1, 0, 0, 4 * j + 16, 4 * j + 17, 4 * j + 19);
        cycle(0, 0, "R2");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            for (int j = 0; j < 4; j++)
                set_slot(j, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                         $urandom_range(0, 7), $urandom_range(0, 7),
                         $urandom_range(0, 31), $urandom_range(0, 7));
            cycle($urandom_range(0, 4), $urandom_range(0, 39) == 0, "R5");
        end
        clear_slots();
        cycle(0, 0, "R2");
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule